// File: doc/BRIEF.md
# Shadowed Configuration Register Bank with Commit

This block is the register file that sits behind a serial host port. The port hands it single-byte writes and reads by address. Each slot of the bank has a fixed kind chosen by a parameter table. A shadowed slot keeps a staging byte and an active byte. A direct slot acts on a write at once. A status slot mirrors an input byte. An unmapped address has no storage at all. The active bytes of every slot are presented on one flat vector for the rest of the chip.

Host writes to shadowed slots collect in their staging bytes. All of them move into the active bytes on a single clock when a commit happens. A commit is requested in one of two ways. The first is any level change on an external strobe pin, which passes through a two-flop synchronizer and a change detector. The second is writing a 1 to bit 0 of the control slot at address 5, a direct slot whose bit clears itself. A small two-state machine turns a request into the commit cycle. In state UPD_IDLE it waits and takes the transition UPD_IDLE→UPD_COMMIT when a request is present. In state UPD_COMMIT it drives the commit pulse, stays in UPD_COMMIT (UPD_COMMIT→UPD_COMMIT) if another request arrives, and otherwise takes UPD_COMMIT→UPD_IDLE. Bits named in a per-slot self-clear mask of a direct slot drop back to 0 one clock after they are written as 1.

Top module: `shadow_reg_bank`

## Requirements
- R1: After reset every active byte on `active_o` is 0, `commit_o` is 0 and reading any shadowed or direct slot returns 0.
- R2: A write to a shadowed slot (default map: addresses 1, 2, 3) changes the byte read back from that address on the next clock, but leaves its active byte unchanged until a commit.
- R3: Any level change of `upd_pin`, rising or falling, that is stable before rising edge E0 raises `commit_o` after edge E2, and the new active bytes appear on `active_o` after edge E3.
- R4: A write of a byte with bit 0 set to address 5 at edge E0 makes that bit read back as 1 for exactly one cycle and as 0 from edge E1 on, raises `commit_o` after E1, and updates the active bytes at E2.
- R5: One commit copies the staging byte of every shadowed slot into its active byte on the same clock edge.
- R6: A write to a direct slot (default map: addresses 0, 5, 6) appears on both the read port and its active byte after the next clock edge.
- R7: A status slot (default map: addresses 4, 7) reads back its byte of `status_i`, ignores writes, and shows 0 on `active_o`.
- R8: Addresses with no slot (8 to 15 by default) read as 0, and writes to them change nothing.
- R9: Bits in a direct slot's self-clear mask (address 6 upper nibble 0xF0, address 5 bit 0) read as 1 for one cycle after being written as 1 and then return to 0; other bits of the same slot hold their value.
- R10: `commit_o` is high for one cycle per commit, and stays high for consecutive cycles while requests keep arriving during a commit.
- R11: A shadowed write that lands on the same edge as a commit does not reach the active byte in that commit: the active byte takes the previous staging value and the new byte stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_addr | input | ADDR_W (4) | Write address |
| wr_data | input | DATA_W (8) | Write byte |
| rd_addr | input | ADDR_W (4) | Read address |
| rd_data | output | DATA_W (8) | Read byte for `rd_addr` (combinational) |
| upd_pin | input | 1 | Asynchronous commit strobe; each level change requests a commit |
| status_i | input | NUM_SLOTS*DATA_W (64) | Status bytes, byte i at bits 8i+7:8i |
| active_o | output | NUM_SLOTS*DATA_W (64) | Active bytes, byte i at bits 8i+7:8i |
| commit_o | output | 1 | High in each cycle whose closing edge commits the staged bytes |

## Verification
Directed sequences stage distinct bytes in all three shadowed slots and then commit them once through the control bit and once through each pin direction. Because the stages and commits use different bytes, a missed slot, an early copy or a late copy can be told apart from a correct commit. Back-to-back control writes and a shadowed write placed on the commit edge separate the merged-request case from the pending-write case. A random phase then mixes writes to every address kind, status changes and pin toggles, and compares the design cycle by cycle with a behavioural model. This shows that status slots, unmapped addresses and self-clearing bits do not interfere with staging.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_LIVE = 2'd1,
        KIND_BUF  = 2'd2,
        KIND_RO   = 2'd3
    } slot_kind_e;

    typedef enum logic {
        UPD_IDLE   = 1'b0,
        UPD_COMMIT = 1'b1
    } upd_state_e;

endpackage

// File: rtl/shadow_update_ctrl.sv
module shadow_update_ctrl
    import shadow_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic ctrl_req_i,
    output logic commit_o
);

    // synchronizer chain plus one extra flop for change detection
    logic [SYNC_STAGES:0] pin_q;
    logic                 pin_edge;
    logic                 req;
    upd_state_e           state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= {pin_q[SYNC_STAGES-1:0], pin_i};
    end

    assign pin_edge = pin_q[SYNC_STAGES] ^ pin_q[SYNC_STAGES-1];
    assign req      = pin_edge | ctrl_req_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            UPD_IDLE:   state_nx = req ? UPD_COMMIT : UPD_IDLE;
            UPD_COMMIT: state_nx = req ? UPD_COMMIT : UPD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_o = (state_q == UPD_COMMIT);
    end

    // R10: a commit cycle always follows a request
    p_commit_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(req));

    // R3: a detected pin change is followed by a commit cycle
    p_pin_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_edge |=> commit_o);

endmodule

// File: rtl/shadow_reg_slot.sv
module shadow_reg_slot
    import shadow_bank_pkg::*;
#(
    parameter int         DW      = 8,
    parameter slot_kind_e KIND    = KIND_LIVE,
    parameter logic [DW-1:0] AC_BITS = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic [DW-1:0] status_byte,
    output logic [DW-1:0] rd_byte,
    output logic [DW-1:0] act_byte
);

    logic unused_inputs;
    assign unused_inputs = ^{clk, rst_n, wr_hit, wr_data, commit, status_byte};

    if (KIND == KIND_BUF) begin : g_buf
        logic [DW-1:0] stg_q, act_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
                act_q <= '0;
            end else begin
                if (wr_hit) stg_q <= wr_data;
                if (commit) act_q <= stg_q;
            end
        end

        assign rd_byte  = stg_q;
        assign act_byte = act_q;

        // R2: active byte only moves on a commit
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(act_byte));

        // R11: commit takes the staging byte present before the edge
        p_commit_old_r11: assert property (@(posedge clk) disable iff (!rst_n)
            commit |=> (act_byte == $past(rd_byte)));
    end else if (KIND == KIND_LIVE) begin : g_live
        logic [DW-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      val_q <= '0;
            else if (wr_hit) val_q <= wr_data;
            else             val_q <= val_q & ~AC_BITS;
        end

        assign rd_byte  = val_q;
        assign act_byte = val_q;

        // R6: a write shows on the next cycle
        p_live_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit |=> (act_byte == $past(wr_data)));

        if (AC_BITS != '0) begin : g_ac
            // R9: self-clearing bits drop after one cycle
            p_ac_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (((act_byte & AC_BITS) != '0) && !wr_hit) |=> ((act_byte & AC_BITS) == '0));
        end
    end else if (KIND == KIND_RO) begin : g_ro
        assign rd_byte  = status_byte;
        assign act_byte = '0;
    end else begin : g_none
        assign rd_byte  = '0;
        assign act_byte = '0;
    end

endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
    import shadow_bank_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int UPD_SLOT  = 5,
    parameter logic [2*NUM_SLOTS-1:0] KIND_MAP = {
        KIND_RO, KIND_LIVE, KIND_LIVE, KIND_RO,
        KIND_BUF, KIND_BUF, KIND_BUF, KIND_LIVE},
    parameter logic [NUM_SLOTS*DATA_W-1:0] AC_MAP = 64'h00F0_0100_0000_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    input  logic                        upd_pin,
    input  logic [NUM_SLOTS*DATA_W-1:0] status_i,
    output logic [NUM_SLOTS*DATA_W-1:0] active_o,
    output logic                        commit_o
);

    localparam int VEC_W = NUM_SLOTS * DATA_W;

    logic [DATA_W-1:0] rd_bytes  [NUM_SLOTS];
    logic [DATA_W-1:0] act_bytes [NUM_SLOTS];
    logic              ctrl_req;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(i));

        shadow_reg_slot #(
            .DW      (DATA_W),
            .KIND    (slot_kind_e'(KIND_MAP[2*i +: 2])),
            .AC_BITS (AC_MAP[DATA_W*i +: DATA_W])
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_hit      (hit),
            .wr_data     (wr_data),
            .commit      (commit_o),
            .status_byte (status_i[DATA_W*i +: DATA_W]),
            .rd_byte     (rd_bytes[i]),
            .act_byte    (act_bytes[i])
        );

        assign active_o[DATA_W*i +: DATA_W] = act_bytes[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = rd_bytes[i];
        end
    end

    assign ctrl_req = act_bytes[UPD_SLOT][0];

    shadow_update_ctrl #(
        .SYNC_STAGES (2)
    ) u_upd (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (upd_pin),
        .ctrl_req_i (ctrl_req),
        .commit_o   (commit_o)
    );

    // R8: addresses without a slot read as zero
    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_addr} >= (ADDR_W+1)'(NUM_SLOTS)) |-> (rd_data == '0));

    // R4: a set control bit leads to a commit cycle
    p_ctrl_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_req) |=> commit_o);

    // R1: nothing is active right after reset
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (active_o == VEC_W'(0)));

endmodule

// File: tb/sim_shadow_reg_bank.sv
module sim_shadow_reg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        upd_pin = 1'b0;
    logic [63:0] status_i = '0;
    logic [63:0] active_o;
    logic        commit_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    shadow_reg_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .upd_pin(upd_pin), .status_i(status_i), .active_o(active_o),
        .commit_o(commit_o)
    );

    // ---------------- behavioural reference model ----------------
    // kind: 0 none, 1 direct, 2 shadowed, 3 status
    int       kind [8] = '{1, 2, 2, 2, 3, 1, 1, 3};
    bit [7:0] acm  [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'hF0, 8'h00};
    bit [7:0] m_stg [8];
    bit [7:0] m_act [8];
    bit [7:0] m_live[8];
    bit       m_commit = 0;
    bit       pin_hist[$] = '{0, 0, 0};   // newest first: last three edge samples

    function automatic bit [63:0] exp_active();
        bit [63:0] v = '0;
        for (int i = 0; i < 8; i++) begin
            if (kind[i] == 1) v[8*i +: 8] = m_live[i];
            else if (kind[i] == 2) v[8*i +: 8] = m_act[i];
        end
        return v;
    endfunction

    function automatic bit [7:0] exp_read(int a);
        if (a > 7) return 8'h00;
        case (kind[a])
            1: return m_live[a];
            2: return m_stg[a];
            3: return status_i[8*a +: 8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        bit req, now;
        req = (pin_hist[1] != pin_hist[2]) || m_live[5][0];
        now = m_commit;
        for (int i = 0; i < 8; i++) begin
            if (now && kind[i] == 2) m_act[i] = m_stg[i];
            if (kind[i] == 1) m_live[i] = m_live[i] & ~acm[i];
        end
        if (wr_en && wr_addr < 8) begin
            if (kind[wr_addr] == 2) m_stg[wr_addr] = wr_data;
            else if (kind[wr_addr] == 1) m_live[wr_addr] = wr_data;
        end
        m_commit = req;
        pin_hist.push_front(upd_pin);
        void'(pin_hist.pop_back());
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_stg[i] = 0; m_act[i] = 0; m_live[i] = 0;
            end
            m_commit = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            model_step();
            #2;
            total++;
            if (active_o !== exp_active() || commit_o !== m_commit ||
                rd_data !== exp_read(int'(rd_addr))) begin
                bad++;
                $display("FAIL MODEL R2/R3/R5/R6/R7/R8/R9/R10 act=%h/%h exp=%h/%h rd=%h exp=%h",
                         active_o, commit_o, exp_active(), m_commit, rd_data,
                         exp_read(int'(rd_addr)));
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
        nxt();
        wr_en = 0;
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        rd_addr = 4'(a);
        #0.5;
        chk(tag, 64'(rd_data), 64'(exp));
    endtask

    function automatic logic [7:0] act(int i);
        return active_o[8*i +: 8];
    endfunction

    initial begin : watchdog
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) nxt();
        rst_n = 1;
        nxt();
        // R1
        chk("R1 active", active_o, 64'h0);
        chk("R1 commit", 64'(commit_o), 64'h0);
        rd_chk("R1 read slot0", 0, 8'h00);
        rd_chk("R1 read slot2", 2, 8'h00);

        // R7: status slot
        status_i[8*4 +: 8] = 8'hA5;
        rd_chk("R7 status read", 4, 8'hA5);
        wr(4, 8'hFF);
        rd_chk("R7 write ignored", 4, 8'hA5);
        chk("R7 active zero", 64'(act(4)), 64'h0);

        // R8: unmapped
        wr(9, 8'h77);
        rd_chk("R8 unmapped read", 9, 8'h00);
        chk("R8 nothing changed", active_o, 64'h0);

        // R6: direct slot
        wr(0, 8'h3C);
        chk("R6 active", 64'(act(0)), 64'h3C);
        rd_chk("R6 read", 0, 8'h3C);

        // R2: staging
        wr(1, 8'h11); wr(2, 8'h22); wr(3, 8'h33);
        rd_chk("R2 staged read", 1, 8'h11);
        chk("R2 active held", 64'({act(3), act(2), act(1)}), 64'h0);

        // R4 + R5: commit by control bit
        wr(5, 8'h01);
        rd_chk("R4 bit set one cycle", 5, 8'h01);
        nxt();
        rd_chk("R4 bit cleared", 5, 8'h00);
        chk("R4 commit high", 64'(commit_o), 64'h1);
        chk("R4 not yet active", 64'(act(1)), 64'h0);
        nxt();
        chk("R5 all slots together", 64'({act(3), act(2), act(1)}), 64'h332211);
        chk("R10 single pulse", 64'(commit_o), 64'h0);

        // R3: rising pin
        wr(1, 8'h44); wr(2, 8'h55); wr(3, 8'h66);
        upd_pin = 1;
        nxt(); nxt(); nxt();
        chk("R3 commit after E2", 64'(commit_o), 64'h1);
        chk("R3 old before E3", 64'(act(1)), 64'h11);
        nxt();
        chk("R3 rising commit", 64'({act(3), act(2), act(1)}), 64'h665544);
        // R3: falling pin
        wr(1, 8'h77);
        upd_pin = 0;
        repeat (4) nxt();
        chk("R3 falling commit", 64'(act(1)), 64'h77);

        // R9: self-clearing nibble
        wr(6, 8'hFF);
        chk("R9 set", 64'(act(6)), 64'hFF);
        nxt();
        chk("R9 cleared upper", 64'(act(6)), 64'h0F);

        // R11: write on commit edge
        wr(1, 8'hA1);
        wr(5, 8'h01);
        nxt();
        chk("R11 commit cycle", 64'(commit_o), 64'h1);
        wr(1, 8'hB2);
        chk("R11 active old staging", 64'(act(1)), 64'hA1);
        rd_chk("R11 new byte pending", 1, 8'hB2);

        // R10: back-to-back requests
        repeat (3) nxt();
        wr(5, 8'h01); wr(5, 8'h01);
        chk("R10 commit first", 64'(commit_o), 64'h1);
        nxt();
        chk("R10 commit extended", 64'(commit_o), 64'h1);
        nxt();
        chk("R10 commit ends", 64'(commit_o), 64'h0);
        chk("R10 pending applied", 64'(act(1)), 64'hB2);

        // random phase, checked by the model every clock
        for (int n = 0; n < 2000; n++) begin
            wr_en   = ($urandom_range(0, 2) != 0);
            wr_addr = 4'($urandom_range(0, 15));
            wr_data = 8'($urandom);
            rd_addr = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 15) == 0) upd_pin = ~upd_pin;
            if ($urandom_range(0, 7) == 0) status_i = {$urandom, $urandom};
            nxt();
        end
        wr_en = 0;
        repeat (4) nxt();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule